// File: doc/BRIEF.md
# Bus Master Privilege Access Controller

This block sits on a peripheral register bus and decides, for every transaction, whether the requesting bus master's supervisor attribute is honoured or demoted to user mode. It holds a master privilege register with one bit per master. It also holds a bank of peripheral access control registers. Each of these registers carries one 4-bit access-level field for each of two peripheral modules. Other logic interprets those fields; this block only stores them.

Writes to the block's own control registers are accepted only from trusted masters. Master 0, the processor core, is always trusted. Any other master is trusted only while its privilege bit is set. A write from an untrusted master gets an error response and leaves every register unchanged. The error flag and the effective attribute are combinational, so they are valid in the same cycle as the access.

Top module: `master_priv_guard`

## Requirements
- R1: After reset the privilege register reads 0x03, so masters 0 and 1 are privileged. Every access control register reads 0x00.
- R2: While the privilege bit of master `mst_id` is 0, `eff_sup` is 0, whatever `sup_in` is.
- R3: While the privilege bit of master `mst_id` is 1, `eff_sup` equals `sup_in`. `eff_sup` is never 1 while `sup_in` is 0.
- R4: A write to a control register from an untrusted master drives `err` high in the same cycle. It changes no register.
- R5: Master 0 is trusted regardless of the register contents, and its writes never raise `err`. Bit 0 of the privilege register always reads 1, and a write cannot clear it.
- R6: Bits 7..4 of the privilege register ignore writes and always read 0.
- R7: A write from a trusted master takes effect at the next rising clock edge. For the privilege register, bit n (n = 0..3) belongs to master n, and bits 3..1 take the written value. For an access control register, all 8 bits take the written value: bits 3..0 hold the first module's field and bits 7..4 hold the second module's field.
- R8: A read (`wr_en` = 0) from any master never raises `err` and returns the current register contents. Unmapped addresses read 0. A write to an unmapped address gives no error and has no effect.
- R9: The privilege register is at byte address 0x20. Access control register k (k = 0..N_PAC-1) is at 0x24 + k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | 1 = write, 0 = read |
| mst_id | input | 2 | Requesting master number |
| sup_in | input | 1 | Supervisor attribute driven by the master |
| rdata | output | 8 | Read data for `addr` |
| err | output | 1 | Error response for a rejected write |
| eff_sup | output | 1 | Effective supervisor attribute |

## Verification
The bench builds the block with its defaults: four masters and nine access control registers starting at 0x24. With these values the last mapped register is at 0x2C and the first unmapped address is 0x2D, so the bench reaches both edges of the register window and 0x23, the gap just below it. Because there are four masters, the bench can grant trust to masters 2 and 3 and then revoke it, so the same master both fails and succeeds at writing. A long random stream of reads and writes then runs against the reference model, with the privilege bits changing as it goes.

// File: rtl/master_priv_guard.sv
module master_priv_guard #(
  parameter int N_MST    = 4,
  parameter int N_PAC    = 9,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int PRIV_ADR = 'h20,
  parameter int PAC_BASE = 'h24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     wr_en,
  input  logic [$clog2(N_MST)-1:0] mst_id,
  input  logic                     sup_in,
  output logic [DATA_W-1:0]        rdata,
  output logic                     err,
  output logic                     eff_sup
);
  localparam int PIDX_W = (N_PAC > 1) ? $clog2(N_PAC) : 1;
  localparam logic [N_MST-1:0] PRIV_RST = N_MST'(3);
  localparam logic [N_MST-1:0] CORE_BIT = N_MST'(1);

  logic [N_MST-1:0]  priv_q;
  logic [DATA_W-1:0] pac_q [N_PAC];

  wire              priv_hit = (int'(addr) == PRIV_ADR);
  wire              pac_hit  = (int'(addr) >= PAC_BASE) && (int'(addr) < PAC_BASE + N_PAC);
  wire [PIDX_W-1:0] pac_idx  = PIDX_W'(int'(addr) - PAC_BASE);
  wire              trusted  = (mst_id == '0) || priv_q[mst_id];
  wire              ctl_hit  = priv_hit || pac_hit;
  wire              wr_ok    = wr_en && ctl_hit && trusted;

  assign err     = wr_en && ctl_hit && !trusted;
  assign eff_sup = priv_q[mst_id] && sup_in;

  always_comb begin
    rdata = '0;
    if (priv_hit)     rdata[N_MST-1:0] = priv_q;
    else if (pac_hit) rdata = pac_q[pac_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priv_q <= PRIV_RST;
      for (int i = 0; i < N_PAC; i++) pac_q[i] <= '0;
    end else if (wr_ok) begin
      if (priv_hit) priv_q <= wdata[N_MST-1:0] | CORE_BIT;
      else          pac_q[pac_idx] <= wdata;
    end
  end

  p_err_no_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (priv_q == $past(priv_q)));
  p_core_never_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_id == '0) |-> !err);
  p_core_bit_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    priv_q[0]);
  p_resv_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    priv_hit |-> (rdata[DATA_W-1:N_MST] == '0));
  p_no_upgrade_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_in |-> !eff_sup);
  p_read_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !err);
endmodule

// File: tb/test_master_priv_guard.sv
module test_master_priv_guard;
  localparam int CLK_PER = 10;
  localparam int N_PAC = 9;
  localparam int PAC_BASE = 'h24;

  logic       clk = 0, rst_n = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic       wr_en = 0, sup_in = 0;
  logic [1:0] mst_id = 0;
  logic [7:0] rdata;
  logic       err, eff_sup;

  int total = 0, bad = 0;
  bit done = 0;
  int mpr_m;
  int pac_m [N_PAC];

  always #(CLK_PER/2) clk = ~clk;

  master_priv_guard i_master_priv_guard (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .mst_id(mst_id), .sup_in(sup_in), .rdata(rdata), .err(err), .eff_sup(eff_sup));

  function automatic int model_read(int a);
    if (a == 'h20) return mpr_m;
    if (a >= PAC_BASE && a < PAC_BASE + N_PAC) return pac_m[a - PAC_BASE];
    return 0;
  endfunction

  function automatic bit is_ctl(int a);
    return (a == 'h20) || (a >= PAC_BASE && a < PAC_BASE + N_PAC);
  endfunction

  task automatic op(bit w, int a, int d, int m, bit s, string req);
    int  exp_rd;
    bit  exp_err, exp_sup, trust;
    @(negedge clk);
    wr_en = w; addr = 8'(a); wdata = 8'(d); mst_id = 2'(m); sup_in = s;
    #1;
    trust   = (m == 0) || mpr_m[m];
    exp_err = w && is_ctl(a) && !trust;
    exp_sup = mpr_m[m] ? s : 1'b0;
    exp_rd  = model_read(a);
    total++;
    if (rdata !== 8'(exp_rd) || err !== exp_err || eff_sup !== exp_sup) begin
      bad++;
      $display("FAIL %s a=%h m=%0d: rdata=%h err=%b eff=%b expected rdata=%h err=%b eff=%b",
               req, a, m, rdata, err, eff_sup, 8'(exp_rd), exp_err, exp_sup);
    end
    @(posedge clk);
    if (w && is_ctl(a) && trust) begin
      if (a == 'h20) mpr_m = (d & 'hF) | 1;
      else pac_m[a - PAC_BASE] = d & 'hFF;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not end, expected it to finish");
    finish_run();
  end

  initial begin
    mpr_m = 3;
    for (int i = 0; i < N_PAC; i++) pac_m[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset contents, R9 register addresses
    op(0, 'h20, 0, 0, 1, "R1");
    for (int k = 0; k < N_PAC; k++) op(0, PAC_BASE + k, 0, 3, 0, "R1");
    // R2 / R3 attribute handling
    op(0, 'h20, 0, 2, 1, "R2");
    op(0, 'h20, 0, 3, 1, "R2");
    op(0, 'h20, 0, 1, 1, "R3");
    op(0, 'h20, 0, 1, 0, "R3");
    // R4 untrusted writes rejected, then readback
    op(1, 'h20, 'hFF, 2, 0, "R4");
    op(1, PAC_BASE + 3, 'h5A, 3, 1, "R4");
    op(0, 'h20, 0, 0, 0, "R4");
    op(0, PAC_BASE + 3, 0, 0, 0, "R4");
    // R5 core cannot clear bit 0, R6 reserved bits
    op(1, 'h20, 'hF0, 0, 1, "R5");
    op(0, 'h20, 0, 1, 1, "R6");
    op(1, 'h20, 'h00, 0, 0, "R5");
    // R7 grant master 2, it writes, then revoke
    op(1, 'h20, 'h04, 0, 0, "R7");
    op(0, 'h20, 0, 2, 1, "R7");
    op(1, PAC_BASE + 8, 'hC3, 2, 1, "R7");
    op(0, PAC_BASE + 8, 0, 1, 0, "R7");
    op(1, PAC_BASE, 'h9E, 2, 0, "R7");
    op(1, 'h20, 'hFA, 2, 0, "R7");
    op(0, 'h20, 0, 3, 1, "R3");
    op(1, 'h20, 'h01, 3, 0, "R7");
    op(1, PAC_BASE + 1, 'h11, 2, 0, "R4");
    op(0, PAC_BASE + 1, 0, 2, 0, "R4");
    // R8 / R9 unmapped edges
    op(1, 'h23, 'hAA, 0, 0, "R8");
    op(1, PAC_BASE + N_PAC, 'hAA, 2, 0, "R8");
    op(0, 'h23, 0, 0, 0, "R9");
    op(0, PAC_BASE + N_PAC, 0, 3, 0, "R9");
    op(0, PAC_BASE + N_PAC - 1, 0, 2, 0, "R9");
    // random traffic
    for (int n = 0; n < 400; n++) begin
      int a;
      a = 'h1E + int'($urandom_range(0, 16));
      op(1'($urandom_range(0, 1)), a, int'($urandom_range(0, 255)),
         int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), "RAND");
    end
    finish_run();
  end
endmodule